// File: doc/BRIEF.md
# Command-Sequence Write Guard

This block sits behind the write-capture stage of a byte-wide programmable memory. It sees every captured write as an address and data pair marked by a one-cycle strobe. From that stream it keeps a protection flag. It tells the storage path, for each write, whether the byte is a command byte that must be thrown away and whether the byte may be committed to the array.

Three specific writes in a row form an unlock prefix. The prefix has two effects. It arms protection, which turns on once the external programming timer reports the end of the current programming period. It also opens an authorised load window, so the writes that follow are committed even if protection is already on. A six-write sequence turns protection off.

When protection is on and a write arrives without the prefix, the guard refuses the commit. The write-cycle timer outside the block still starts, so reads during that period behave as status polls. Consecutive writes of any sequence, and of an authorised load, must arrive within a parameterised gap. Otherwise the sequence is abandoned.

Top module: `wp_guard`

## Requirements
- R1: After reset, `prot_on`, `auth_open`, `suppress` and `commit_ok` are all 0.
- R2: A live write that matches the next step of a command sequence raises `suppress` and keeps `commit_ok` low in the same cycle.
  - The steps are:
    - step 1: data 0xAA to address 0x1555
    - step 2: data 0x55 to address 0x0AAA
    - step 3: either 0xA0 to 0x1555 (unlock) or 0x80 to 0x1555 (disable path)
    - steps 4 to 6 of the disable path: 0xAA to 0x1555, then 0x55 to 0x0AAA, then 0x20 to 0x1555
- R3: After an unlock prefix completes while protection is off, protection is pending. `prot_on` rises on the clock edge at which `prog_done` is sampled high, and not before.
- R4: While `prot_on` is 1 and no load window is open, a live write that is not a command byte gives `commit_ok` = 0 and `suppress` = 0.
- R5: An unlock prefix sets `auth_open` on the edge of its third write. While `auth_open` is 1, every live write is committed (`commit_ok` = 1) and none is suppressed, whatever the protection state.
- R6: A sequence step or a load-window write is accepted only when it arrives no more than `GAP_CYC` clock edges after the previous live write. If `GAP_CYC` edges pass with no live write, any partial sequence returns to idle and `auth_open` clears.
- R7: Completion of the six-write disable sequence clears `prot_on` on the edge of the sixth write. All six writes are suppressed.
- R8: A live write that does not match the expected next step returns the matcher to idle and is handled as ordinary data. It is not suppressed, and it is committed if protection is off. A restart must begin again from step 1.
- R9: While `pwr_ok` is 0, strobes are ignored (`suppress` = 0, `commit_ok` = 0), any partial sequence, pending enable and open window are cleared, and `prot_on` holds its value.
- R10: While protection is off, a live write that is not a command byte is committed (`commit_ok` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply good; low inhibits all writes |
| wr_stb | input | 1 | One-cycle strobe of a captured write |
| wr_addr | input | ADDR_W (13) | Captured write address |
| wr_data | input | DATA_W (8) | Captured write data |
| prog_done | input | 1 | Pulse at the end of a programming period |
| prot_on | output | 1 | Protection flag |
| auth_open | output | 1 | Authorised load window is open |
| suppress | output | 1 | Current write is a command byte; do not store it |
| commit_ok | output | 1 | Current write may be stored in the array |

## Verification
A matcher stuck at the wrong step shows up on the very next strobe. Either `suppress` stays low on a correct command byte, or it rises on a byte that should pass as data. A lost or extra gap-timer count moves the abort by one edge, and the bench probes the exact boundary in both directions. A wrong protection or window state changes `commit_ok` on the first ordinary write after it. A mis-timed enable or disable is visible on `prot_on` one edge after `prog_done` or after the sixth command byte.

// File: rtl/wp_pkg.sv
`timescale 1ns/100ps
package wp_pkg;
    // command data codes
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] OP_UNLOCK  = 8'hA0;
    localparam logic [7:0] OP_DIS_PFX = 8'h80;
    localparam logic [7:0] OP_DIS_FIN = 8'h20;

    // matcher position: number of command bytes matched so far
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ONE,
        ST_TWO,
        ST_DIS3,
        ST_DIS4,
        ST_DIS5
    } seq_step_e;
endpackage

// File: rtl/wp_gap_timer.sv
`timescale 1ns/100ps
module wp_gap_timer #(
    parameter int GAP_CYC = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic armed,
    output logic expire
);
    localparam int CW = $clog2(GAP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } gap_state_t;

    gap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LAST) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
        expire = armed && !stb && (st_q.cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wp_seq_matcher.sv
`timescale 1ns/100ps
module wp_seq_matcher
    import wp_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] A_PRI = 13'h1555,
    parameter logic [ADDR_W-1:0] A_ALT = 13'h0AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              expire,
    output logic              hit,
    output logic              unlock_fire,
    output logic              disable_fire,
    output logic              busy
);
    typedef struct packed {
        seq_step_e step;
    } match_state_t;

    match_state_t st_d, st_q;
    logic at_pri, at_alt;

    always_comb begin
        st_d         = st_q;
        hit          = 1'b0;
        unlock_fire  = 1'b0;
        disable_fire = 1'b0;
        at_pri       = (addr == A_PRI);
        at_alt       = (addr == A_ALT);
        if (clr) begin
            st_d.step = ST_IDLE;
        end else if (stb) begin
            st_d.step = ST_IDLE;
            unique case (st_q.step)
                ST_IDLE: if (at_pri && data == DATA_W'(KEY_FIRST)) begin
                    hit = 1'b1; st_d.step = ST_ONE;
                end
                ST_ONE: if (at_alt && data == DATA_W'(KEY_SECOND)) begin
                    hit = 1'b1; st_d.step = ST_TWO;
                end
                ST_TWO: begin
                    if (at_pri && data == DATA_W'(OP_UNLOCK)) begin
                        hit = 1'b1; unlock_fire = 1'b1;
                    end else if (at_pri && data == DATA_W'(OP_DIS_PFX)) begin
                        hit = 1'b1; st_d.step = ST_DIS3;
                    end
                end
                ST_DIS3: if (at_pri && data == DATA_W'(KEY_FIRST)) begin
                    hit = 1'b1; st_d.step = ST_DIS4;
                end
                ST_DIS4: if (at_alt && data == DATA_W'(KEY_SECOND)) begin
                    hit = 1'b1; st_d.step = ST_DIS5;
                end
                ST_DIS5: if (at_pri && data == DATA_W'(OP_DIS_FIN)) begin
                    hit = 1'b1; disable_fire = 1'b1;
                end
                default: st_d.step = ST_IDLE;
            endcase
        end else if (expire) begin
            st_d.step = ST_IDLE;
        end
        busy = (st_q.step != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.step <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wp_guard.sv
`timescale 1ns/100ps
module wp_guard #(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int GAP_CYC = 30000,
    parameter logic [ADDR_W-1:0] A_PRI = 13'h1555,
    parameter logic [ADDR_W-1:0] A_ALT = 13'h0AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_done,
    output logic              prot_on,
    output logic              auth_open,
    output logic              suppress,
    output logic              commit_ok
);
    typedef struct packed {
        logic prot;
        logic pend;
        logic auth;
    } guard_state_t;

    guard_state_t st_d, st_q;

    logic stb_live, m_stb, m_hit, m_unlock, m_disable, m_busy, gap_expire;

    assign stb_live = wr_stb && pwr_ok;
    assign m_stb    = stb_live && !st_q.auth;

    wp_seq_matcher #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .A_PRI(A_PRI), .A_ALT(A_ALT)
    ) u_match (
        .clk(clk), .rst_n(rst_n), .clr(!pwr_ok), .stb(m_stb),
        .addr(wr_addr), .data(wr_data), .expire(gap_expire),
        .hit(m_hit), .unlock_fire(m_unlock), .disable_fire(m_disable),
        .busy(m_busy)
    );

    wp_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .stb(stb_live),
        .armed(m_busy || st_q.auth), .expire(gap_expire)
    );

    always_comb begin
        st_d = st_q;
        if (prog_done && st_q.pend) begin
            st_d.prot = 1'b1;
            st_d.pend = 1'b0;
        end
        if (m_unlock) begin
            st_d.auth = 1'b1;
            if (!st_q.prot) st_d.pend = 1'b1;
        end
        if (m_disable) begin
            st_d.prot = 1'b0;
            st_d.pend = 1'b0;
        end
        if (gap_expire) st_d.auth = 1'b0;
        if (!pwr_ok) begin
            st_d.prot = st_q.prot;
            st_d.pend = 1'b0;
            st_d.auth = 1'b0;
        end
        suppress  = m_hit;
        commit_ok = stb_live && !m_hit && (st_q.auth || !st_q.prot);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_on   = st_q.prot;
    assign auth_open = st_q.auth;
endmodule

// File: rtl/wp_guard_chk.sv
`timescale 1ns/100ps
module wp_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok,
    input logic wr_stb,
    input logic prog_done,
    input logic prot_on,
    input logic auth_open,
    input logic suppress,
    input logic commit_ok
);
    assert_cmd_not_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |-> !commit_ok);

    assert_enable_after_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(prog_done));

    assert_blocked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && !auth_open && wr_stb && !suppress) |-> !commit_ok);

    assert_window_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_open && wr_stb && pwr_ok) |-> (commit_ok && !suppress));

    assert_clear_by_command_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(suppress));

    assert_low_supply_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (!suppress && !commit_ok));

    assert_low_supply_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> $stable(prot_on));
endmodule

bind wp_guard wp_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .wr_stb(wr_stb),
    .prog_done(prog_done), .prot_on(prot_on), .auth_open(auth_open),
    .suppress(suppress), .commit_ok(commit_ok)
);

// File: tb/sim_wp_guard.sv
`timescale 1ns/100ps
module sim_wp_guard;
    localparam int GAP = 8;
    localparam logic [12:0] AP = 13'h1555;
    localparam logic [12:0] AA = 13'h0AAA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic wr_stb = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic prog_done = 1'b0;
    logic prot_on, auth_open, suppress, commit_ok;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int m_step = 0;   // command bytes matched (0..5)
    bit m_auth = 0, m_pend = 0, m_prot = 0;
    int m_gap = 0;

    always #2.5 clk = ~clk;

    wp_guard #(.GAP_CYC(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
        .prot_on(prot_on), .auth_open(auth_open), .suppress(suppress),
        .commit_ok(commit_ok)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // disable sequence, element k (0..5)
    function automatic logic [20:0] dis_elem(input int k);
        case (k)
            0: return {AP, 8'hAA};
            1: return {AA, 8'h55};
            2: return {AP, 8'h80};
            3: return {AP, 8'hAA};
            4: return {AA, 8'h55};
            default: return {AP, 8'h20};
        endcase
    endfunction

    task automatic cyc(input logic s, input logic [12:0] a, input logic [7:0] d,
                       input logic pd, input logic pw, input string tag_in);
        bit live, hit, is_unlock, exp_commit, old_prot, armed;
        string tag;
        @(negedge clk);
        wr_stb = s; wr_addr = a; wr_data = d; prog_done = pd; pwr_ok = pw;
        #1;
        live = s && pw;
        hit = 0; is_unlock = 0;
        if (live && !m_auth) begin
            if ({a, d} == dis_elem(m_step)) hit = 1;
            if (m_step == 2 && {a, d} == {AP, 8'hA0}) begin hit = 1; is_unlock = 1; end
        end
        exp_commit = live && !hit && (m_auth || !m_prot);
        tag = tag_in;
        if (tag == "") begin
            if (!pw) tag = "R9";
            else if (hit) tag = "R2";
            else if (m_auth) tag = "R5";
            else if (m_prot) tag = "R4";
            else tag = "R10";
        end
        chk(tag, "suppress", suppress, hit);
        chk(tag, "commit_ok", commit_ok, exp_commit);
        // model update, all from pre-edge values
        old_prot = m_prot;
        armed = (m_step != 0) || m_auth;
        if (pd && m_pend) begin m_prot = 1; m_pend = 0; end
        if (live && !m_auth) begin
            if (!hit) m_step = 0;
            else if (is_unlock) begin
                m_step = 0; m_auth = 1;
                if (!old_prot) m_pend = 1;
            end else if (m_step == 5) begin
                m_step = 0; m_prot = 0; m_pend = 0;
            end else m_step++;
        end
        if (live) m_gap = 0;
        else begin
            if (m_gap == GAP - 1 && armed) begin m_step = 0; m_auth = 0; end
            if (m_gap < GAP - 1) m_gap++;
        end
        if (!pw) begin m_prot = old_prot; m_pend = 0; m_auth = 0; m_step = 0; end
        @(posedge clk);
        #1;
        chk(tag, "prot_on", prot_on, m_prot);
        chk(tag, "auth_open", auth_open, m_auth);
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, a, d, 1'b0, 1'b1, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b0, 1'b1, tag);
    endtask

    task automatic unlock(input string tag);
        wr(AP, 8'hAA, tag); wr(AA, 8'h55, tag); wr(AP, 8'hA0, tag);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        #12;
        chk("R1", "prot_on", prot_on, 1'b0);
        chk("R1", "auth_open", auth_open, 1'b0);
        chk("R1", "suppress", suppress, 1'b0);
        chk("R1", "commit_ok", commit_ok, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        wr(13'h0100, 8'h12, "R10");            // ordinary write, unprotected
        unlock("R2");                           // enable prefix
        wr(13'h0040, 8'h01, "R5");              // authorised load
        wr(13'h0041, 8'h02, "R5");
        idle(GAP + 1, "R6");                    // window closes
        idle(2, "R3");                          // still pending, not yet on
        cyc(1'b0, '0, '0, 1'b1, 1'b1, "R3");    // programming period ends
        wr(13'h0200, 8'h77, "R4");              // blocked write
        unlock("R2");
        wr(13'h0300, 8'h5A, "R5");              // authorised while protected
        wr(13'h0301, 8'hA5, "R5");
        idle(GAP + 1, "R6");
        // gap exactly at the limit: accepted
        wr(AP, 8'hAA, "R6"); idle(GAP - 1, "R6");
        wr(AA, 8'h55, "R6"); idle(GAP - 1, "R6");
        wr(AP, 8'hA0, "R6");
        idle(GAP + 1, "R6");
        // one edge too late: aborted
        wr(AP, 8'hAA, "R6"); idle(GAP, "R6");
        wr(AA, 8'h55, "R6");
        idle(GAP + 1, "R6");
        // mismatch returns to idle, no implicit restart
        wr(AP, 8'hAA, "R8"); wr(AA, 8'h33, "R8");
        wr(AA, 8'h55, "R8"); wr(AP, 8'hA0, "R8");
        idle(GAP + 1, "R8");
        // disable sequence
        wr(AP, 8'hAA, "R7"); wr(AA, 8'h55, "R7"); wr(AP, 8'h80, "R7");
        wr(AP, 8'hAA, "R7"); wr(AA, 8'h55, "R7"); wr(AP, 8'h20, "R7");
        wr(13'h0400, 8'h11, "R10");
        idle(GAP + 1, "R8");
        // re-enable then low supply
        unlock("R2"); idle(GAP + 1, "R6");
        cyc(1'b0, '0, '0, 1'b1, 1'b1, "R3");
        wr(AP, 8'hAA, "R9"); wr(AA, 8'h55, "R9");
        cyc(1'b1, AP, 8'hA0, 1'b0, 1'b0, "R9");
        cyc(1'b1, 13'h0010, 8'h44, 1'b1, 1'b0, "R9");
        wr(AP, 8'hA0, "R9");
        idle(GAP + 1, "R9");

        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            int kind;
            logic pd, pw;
            logic [20:0] e;
            kind = int'($urandom_range(0, 99));
            pd = ($urandom_range(0, 99) < 5);
            pw = ($urandom_range(0, 99) >= 3);
            if (kind < 40) begin
                if ($urandom_range(0, 5) == 0) e = {AP, 8'hA0};
                else e = dis_elem(int'($urandom_range(0, 5)));
                cyc(1'b1, e[20:8], e[7:0], pd, pw, "");
            end else if (kind < 65) begin
                cyc(1'b1, 13'($urandom), 8'($urandom), pd, pw, "");
            end else if (kind < 97) begin
                cyc(1'b0, '0, '0, pd, pw, "");
            end else begin
                idle(GAP + int'($urandom_range(0, 2)) - 1, "R6");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule